// File: doc/BRIEF.md
# Index-Port Real-Time Clock

This block is a calendar clock reached through a pair of byte-wide ports. A write to the index port (port select low) stores an 8-bit register number. Later accesses to the data port (port select high) read or write the register that number selects. The block holds seven time fields: seconds, minutes, hours, weekday, day of month, month and year. It also holds four control slots. Software may write the control slots, but the writes change nothing.

A programmable divider on the system clock produces a periodic interrupt pulse. A 10-bit counter counts these pulses. Every 1024th pulse moves the seconds field forward by one, modulo 60. No other field carries. All values are plain binary. Month is held zero-based and year is held with an offset of 52. Both offsets are applied when the field is written and removed when it is read, so a value that is written reads back unchanged. An access to a register number that is not mapped raises a one-cycle error pulse.

Top module: `port_rtc`

## Requirements
- R1: A write with port select 0 stores wdata as the current index. A read with port select 0 returns that index. The index changes only on an index-port write.
- R2: A read (rd_en_i high for one cycle) sets rd_valid_o high with the data in rdata_o on the next cycle. When no read was made the cycle before, rd_valid_o is 0 and rdata_o is 0.
- R3: irq_o is a pulse one cycle wide. With divider value D held steady it repeats every D+1 clock cycles. With D=0 it is high on every cycle.
- R4: A 10-bit counter counts irq pulses. The pulse seen while the counter is 1023 wraps the counter and sets seconds to (seconds+1) mod 60, with the sum taken in 9 bits, so 59 becomes 0 and 200 becomes 21. A data write to seconds on that same cycle takes priority over the advance.
- R5: The fields are mapped at indices 0x20 seconds, 0x21 minutes, 0x22 hours, 0x23 weekday and 0x24 day of month, and they store and return the written byte unchanged.
- R6: Month is at index 0x25. It stores (w-1) mod 256 and returns (stored+1) mod 256, so a write of 12 reads 12 and a write of 0 reads 0.
- R7: Year is at index 0x26. It stores (w+52) mod 256 and returns (stored-52) mod 256, so a write of 250 reads 250.
- R8: Control indices 0x30 to 0x33 accept writes, which change nothing. Reading them returns 0. Neither kind of access raises err_o.
- R9: A data-port access to any other index sets err_o for one cycle, on the cycle after the access. A read returns 0. A write changes no field.
- R10: After reset irq_o, rd_valid_o and err_o are 0. Seconds, minutes, hours, weekday and day of month read 0, month reads 1 and year reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div_i | input | DIV_W | Interrupt period minus one, in clock cycles |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| port_sel_i | input | 1 | 0 selects the index port, 1 the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read |
| rd_valid_o | output | 1 | Marks rdata_o as carrying a read result |
| err_o | output | 1 | Pulse for an access to an unmapped index |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The read result, rd_valid_o and err_o all come out one cycle after the access strobe. The bench drives every access on a falling edge and samples these outputs on the next falling edge, one register later. irq_o rises D+1 cycles after the divider count restarts. A seconds advance can be read from the cycle after the 1024th pulse. A behavioural reference model updates on each rising edge and is compared against all four outputs on every falling edge. Directed reads poll the seconds field to confirm the wrap value and the spacing between advances.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 8;
  localparam int NFLD = 7;
  localparam int NCTL = 4;
  localparam int F_SEC  = 0;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam logic [DW-1:0] FLD_BASE = 8'h20;
  localparam logic [DW-1:0] FLD_END  = FLD_BASE + 8'(NFLD);
  localparam logic [DW-1:0] CTL_BASE = 8'h30;
  localparam logic [DW-1:0] CTL_END  = CTL_BASE + 8'(NCTL);
  localparam logic [DW-1:0] YEAR_OFS = 8'd52;
  localparam logic [DW-1:0] SEC_MOD  = 8'd60;

  // value held in the field after a data-port write
  function automatic logic [DW-1:0] store_fld(int k, logic [DW-1:0] w);
    case (k)
      F_MON:   return w - 8'd1;
      F_YEAR:  return w + YEAR_OFS;
      default: return w;
    endcase
  endfunction

  // value presented on a data-port read
  function automatic logic [DW-1:0] show_fld(int k, logic [DW-1:0] s);
    case (k)
      F_MON:   return s + 8'd1;
      F_YEAR:  return s - YEAR_OFS;
      default: return s;
    endcase
  endfunction

  // reset contents: every field reads zero except month, which reads one
  function automatic logic [DW-1:0] rst_fld(int k);
    return (k == F_YEAR) ? YEAR_OFS : 8'd0;
  endfunction

  // seconds step, summed in nine bits so large written values wrap sanely
  function automatic logic [DW-1:0] sec_next(logic [DW-1:0] s);
    logic [DW:0] t;
    t = {1'b0, s} + 9'd1;
    return 8'(t % {1'b0, SEC_MOD});
  endfunction
endpackage

// File: rtl/port_rtc_tick.sv
module port_rtc_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             irq_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_limit;

  // >= so that lowering the divider mid-count restarts at once
  assign at_limit = (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else if (at_limit) begin
      cnt_q <= '0;
      irq_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      irq_o <= 1'b0;
    end
  end

  // R3: a pulse is always issued together with a restarted count
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == '0));
endmodule

// File: rtl/port_rtc_secdiv.sv
module port_rtc_secdiv #(
  parameter int IRQ_PER_SEC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  output logic sec_adv_o
);
  localparam int CW = $clog2(IRQ_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(IRQ_PER_SEC - 1);

  logic [CW-1:0] icnt_q;

  assign sec_adv_o = irq_i && (icnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      icnt_q <= '0;
    else if (irq_i)
      icnt_q <= (icnt_q == LAST) ? '0 : icnt_q + 1'b1;
  end

  // R4: the pulse that advances seconds also wraps the pulse counter
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv_o |=> (icnt_q == '0));
endmodule

// File: rtl/port_rtc_regs.sv
module port_rtc_regs
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          port_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_adv_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_valid_o,
  output logic          err_o
);
  logic [DW-1:0] idx_q;
  logic [DW-1:0] fld_w [NFLD];
  logic [DW-1:0] fofs;
  logic [DW-1:0] fld_view;
  logic idx_wr, data_wr, data_rd;
  logic in_fld, in_ctl, sec_wr;

  assign idx_wr  = wr_en_i & ~port_sel_i;
  assign data_wr = wr_en_i &  port_sel_i;
  assign data_rd = rd_en_i &  port_sel_i;
  assign fofs    = idx_q - FLD_BASE;
  assign in_fld  = (idx_q >= FLD_BASE) && (idx_q < FLD_END);
  assign in_ctl  = (idx_q >= CTL_BASE) && (idx_q < CTL_END);
  assign sec_wr  = data_wr && in_fld && (fofs == 8'(F_SEC));

  always_comb begin
    fld_view = '0;
    for (int k = 0; k < NFLD; k++)
      if (in_fld && (fofs == 8'(k)))
        fld_view = show_fld(k, fld_w[k]);
  end

  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    logic          wr_k;
    logic [DW-1:0] q;
    assign wr_k = data_wr && in_fld && (fofs == 8'(k));
    if (k == F_SEC) begin : g_sec
      // a software write wins over a same-cycle advance
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= rst_fld(k);
        else if (wr_k)      q <= store_fld(k, wdata_i);
        else if (sec_adv_i) q <= sec_next(q);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= rst_fld(k);
        else if (wr_k) q <= store_fld(k, wdata_i);
      end
    end
    assign fld_w[k] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= wdata_i;
      rd_valid_o <= rd_en_i;
      if (!rd_en_i)        rdata_o <= '0;
      else if (!port_sel_i) rdata_o <= idx_q;
      else                 rdata_o <= fld_view;
      err_o <= (data_wr | data_rd) & ~(in_fld | in_ctl);
    end
  end

  // R1: index only moves on an index-port write
  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));
  // R2: valid data only follows a read strobe
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_en_i));
  // R4: an advance never leaves seconds out of range
  p_sec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_adv_i && !sec_wr) |=> (fld_w[F_SEC] < SEC_MOD));
  // R9: a faulting read returns zero
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && rd_valid_o) |-> (rdata_o == '0));
endmodule

// File: rtl/port_rtc.sv
module port_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int IRQ_PER_SEC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tick_div_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             port_sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rd_valid_o,
  output logic             err_o,
  output logic             irq_o
);
  logic irq_w;
  logic sec_adv_w;

  port_rtc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .div_i (tick_div_i),
    .irq_o (irq_w)
  );

  port_rtc_secdiv #(.IRQ_PER_SEC(IRQ_PER_SEC)) u_secdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_w),
    .sec_adv_o (sec_adv_w)
  );

  port_rtc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .port_sel_i (port_sel_i),
    .wdata_i    (wdata_i),
    .sec_adv_i  (sec_adv_w),
    .rdata_o    (rdata_o),
    .rd_valid_o (rd_valid_o),
    .err_o      (err_o)
  );

  assign irq_o = irq_w;
endmodule

// File: tb/port_rtc_bench.sv
`timescale 1ns/1ps
module port_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tick_div = 16'd9;
  logic        wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic        rd_valid, err, irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  port_rtc u_port_rtc (
    .clk(clk), .rst_n(rst_n), .tick_div_i(tick_div),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .port_sel_i(port_sel), .wdata_i(wdata),
    .rdata_o(rdata), .rd_valid_o(rd_valid), .err_o(err), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_icnt, m_idx;
  int m_f [7];
  int e_irq, e_val, e_dat, e_err;

  function automatic bit is_fld(int i); return i >= 32 && i <= 38; endfunction
  function automatic bit is_ctl(int i); return i >= 48 && i <= 51; endfunction
  function automatic int view(int k, int s);
    if (k == 5) return (s + 1) % 256;
    if (k == 6) return (s + 204) % 256;
    return s;
  endfunction
  function automatic int keep(int k, int w);
    if (k == 5) return (w + 255) % 256;
    if (k == 6) return (w + 52) % 256;
    return w;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_icnt = 0; m_idx = 0;
      foreach (m_f[i]) m_f[i] = 0;
      m_f[6] = 52;
      e_irq = 0; e_val = 0; e_dat = 0; e_err = 0;
    end else begin
      bit adv, secw;
      adv = (e_irq == 1) && (m_icnt == 1023);
      if (e_irq == 1) m_icnt = (m_icnt + 1) % 1024;
      if (m_cnt >= int'(tick_div)) begin m_cnt = 0; e_irq = 1; end
      else begin m_cnt++; e_irq = 0; end
      e_val = rd_en;
      if (!rd_en) e_dat = 0;
      else if (!port_sel) e_dat = m_idx;
      else if (is_fld(m_idx)) e_dat = view(m_idx - 32, m_f[m_idx - 32]);
      else e_dat = 0;
      e_err = port_sel && (wr_en || rd_en) && !is_fld(m_idx) && !is_ctl(m_idx);
      secw = wr_en && port_sel && (m_idx == 32);
      if (wr_en && port_sel && is_fld(m_idx)) m_f[m_idx - 32] = keep(m_idx - 32, int'(wdata));
      if (adv && !secw) m_f[0] = (m_f[0] + 1) % 60;
      if (wr_en && !port_sel) m_idx = int'(wdata);
    end
  end

  // every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = 1'b0;
      checks++;
      if (int'(irq) != e_irq) begin
        $display("FAIL R3 irq cyc=%0d actual=%0d expected=%0d", cyc, irq, e_irq); bad = 1'b1;
      end
      if (int'(rd_valid) != e_val || int'(rdata) != e_dat) begin
        $display("FAIL R2 read cyc=%0d actual=%0d/%0h expected=%0d/%0h",
                 cyc, rd_valid, rdata, e_val, e_dat); bad = 1'b1;
      end
      if (int'(err) != e_err) begin
        $display("FAIL R9 err cyc=%0d actual=%0d expected=%0d", cyc, err, e_err); bad = 1'b1;
      end
      if (bad) errors++;
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(bit sel, logic [7:0] d, output logic e);
    @(negedge clk); port_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; e = err;
  endtask

  task automatic get(bit sel, output int v, output logic ok, output logic e);
    @(negedge clk); port_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = int'(rdata); ok = rd_valid; e = err;
  endtask

  task automatic wr_reg(logic [7:0] i, logic [7:0] d);
    logic e;
    put(1'b0, i, e); put(1'b1, d, e);
  endtask

  task automatic rd_reg(logic [7:0] i, output int v);
    logic e, ok;
    put(1'b0, i, e); get(1'b1, v, ok, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, t0, t1, n;
    logic ok, e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 irq after reset", int'(irq), 0);
    check("R10 valid after reset", int'(rd_valid), 0);
    check("R10 err after reset", int'(err), 0);
    rd_reg(8'h20, v); check("R10 seconds reset", v, 0);
    rd_reg(8'h24, v); check("R10 day reset", v, 0);
    rd_reg(8'h25, v); check("R10 month reset", v, 1);
    rd_reg(8'h26, v); check("R10 year reset", v, 0);
    // R1 index readback
    put(1'b0, 8'h22, e);
    get(1'b0, v, ok, e); check("R1 index readback", v, 'h22);
    check("R2 valid on read", int'(ok), 1);
    @(negedge clk); check("R2 valid drops", int'(rd_valid), 0);
    check("R2 data idle zero", int'(rdata), 0);
    // R5 plain fields
    wr_reg(8'h22, 8'd17); wr_reg(8'h21, 8'd45); wr_reg(8'h23, 8'd6); wr_reg(8'h24, 8'd31);
    rd_reg(8'h22, v); check("R5 hours", v, 17);
    rd_reg(8'h21, v); check("R5 minutes", v, 45);
    rd_reg(8'h23, v); check("R5 weekday", v, 6);
    rd_reg(8'h24, v); check("R5 day", v, 31);
    // R6 month offset
    wr_reg(8'h25, 8'd12); rd_reg(8'h25, v); check("R6 month 12", v, 12);
    wr_reg(8'h25, 8'd0);  rd_reg(8'h25, v); check("R6 month 0", v, 0);
    // R7 year offset
    wr_reg(8'h26, 8'd25);  rd_reg(8'h26, v); check("R7 year 25", v, 25);
    wr_reg(8'h26, 8'd250); rd_reg(8'h26, v); check("R7 year 250", v, 250);
    // R8 control slots
    put(1'b0, 8'h31, e); put(1'b1, 8'hFF, e); check("R8 ctl write no err", int'(e), 0);
    get(1'b1, v, ok, e); check("R8 ctl read zero", v, 0); check("R8 ctl read no err", int'(e), 0);
    rd_reg(8'h22, v); check("R8 hours untouched", v, 17);
    // R9 unmapped
    put(1'b0, 8'h40, e); put(1'b1, 8'hAA, e); check("R9 write err", int'(e), 1);
    get(1'b1, v, ok, e); check("R9 read zero", v, 0); check("R9 read err", int'(e), 1);
    @(negedge clk); check("R9 err one cycle", int'(err), 0);
    put(1'b0, 8'h27, e); get(1'b1, v, ok, e); check("R9 past year err", int'(e), 1);
    rd_reg(8'h24, v); check("R9 day untouched", v, 31);
    // R3 interrupt period
    tick_div = 16'd3;
    repeat (8) @(negedge clk);
    n = 0; for (int i = 0; i < 40; i++) begin @(negedge clk); n += int'(irq); end
    check("R3 period 4", n, 10);
    tick_div = 16'd0;
    repeat (2) @(negedge clk);
    n = 0; for (int i = 0; i < 20; i++) begin @(negedge clk); n += int'(irq); end
    check("R3 every cycle", n, 20);
    // R4 seconds advance and wrap
    wr_reg(8'h20, 8'd59);
    put(1'b0, 8'h20, e);
    v = 59; n = 0;
    while (v == 59 && n < 700) begin get(1'b1, v, ok, e); n++; end
    check("R4 wrap 59 to 0", v, 0);
    t0 = cyc;
    n = 0;
    while (v == 0 && n < 700) begin get(1'b1, v, ok, e); n++; end
    t1 = cyc;
    check("R4 next second", v, 1);
    check("R4 1024 pulses apart", int'((t1 - t0) >= 1022 && (t1 - t0) <= 1026), 1);
    wr_reg(8'h20, 8'd200);
    put(1'b0, 8'h20, e);
    v = 200; n = 0;
    while (v == 200 && n < 700) begin get(1'b1, v, ok, e); n++; end
    check("R4 large value wraps", v, 21);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule